// File: doc/BRIEF.md
# Single-Clock Queue with Programmable Watermarks

This block is a first-in first-out queue in one clock domain. Words enter through a write port gated by an enable and leave through a read port gated by a second enable. Two read-side timings are available and chosen when the block is instantiated. In standard timing, a word reaches the data output in the cycle after its read is accepted. In look-ahead timing, the oldest stored word is placed on the output without any request, and a read moves the output on to the next word.

Around the storage sit the status outputs that producers and consumers use to pace themselves. These are full and empty flags, and "one left" flags on each side. There are also two watermark flags with hysteresis, whose thresholds come either from parameters or from input ports. Per-operation outputs report an accepted write, a refused write, valid read data and a refused read. Both sides see the current occupancy as a count.

Top module: `qbuf_fifo`

## Requirements
- R1: A synchronous active-high `rst` empties the queue. In the following cycle `empty` and `prog_empty` read 1. Both counts, `rd_data` and every other flag and pulse output read 0.
- R2: With `MODE = QB_STD`, a read accepted at a clock edge places the oldest word on `rd_data` with `rd_valid` = 1 after that edge. `rd_data` does not change without an accepted read.
- R3: With `MODE = QB_FWFT`, a stored word appears on `rd_data` with `rd_valid` = 1 and `empty` = 0 two edges after its write, with no read issued. An accepted read replaces it with the next word, or raises `empty` when no word remains.
- R4: Words leave in the order they were written, in both modes.
- R5: `full` reads 1 exactly when the occupancy equals `DEPTH`. `almost_full` reads 1 exactly when it equals `DEPTH-1`.
- R6: In standard mode, `empty` reads 1 exactly when the occupancy is 0. `almost_empty` reads 1 exactly when the occupancy is 1.
- R7: A write requested while `full` = 1 stores nothing and leaves the occupancy unchanged. `overflow` pulses for one cycle and `wr_ack` stays 0.
- R8: A read requested while `empty` = 1 pulses `underflow` for one cycle. `rd_valid` stays 0 and the occupancy is unchanged.
- R9: `wr_ack` reads 1 for one cycle after each accepted write.
- R10: `prog_full` sets once the occupancy reaches the full-set threshold. It clears only when the occupancy drops below the full-clear threshold, and holds in between.
- R11: `prog_empty` sets once the occupancy drops to the empty-set threshold or below. It clears only when the occupancy rises above the empty-clear threshold, and holds in between.
- R12: With `THR_FROM_PORT` = 1, the four thresholds are taken from the `*_th` input ports and a change on them applies at once. Otherwise they are taken from the parameters.
- R13: `wr_count` and `rd_count` are `$clog2(DEPTH)+1` bits wide and equal the number of words held. A read and a write accepted in the same cycle leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | Queue holds DEPTH words |
| almost_full | output | 1 | Room for exactly one more word |
| wr_ack | output | 1 | Previous write was accepted |
| overflow | output | 1 | Previous write was refused |
| wr_count | output | $clog2(DEPTH)+1 | Occupancy seen by the writer |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Output word |
| empty | output | 1 | No word available on the read side |
| almost_empty | output | 1 | Exactly one word held |
| rd_valid | output | 1 | `rd_data` carries a valid word |
| underflow | output | 1 | Previous read was refused |
| rd_count | output | $clog2(DEPTH)+1 | Occupancy seen by the reader |
| prog_full | output | 1 | Upper watermark flag with hysteresis |
| prog_empty | output | 1 | Lower watermark flag with hysteresis |
| pf_set_th | input | $clog2(DEPTH)+1 | Full-set threshold when taken from ports |
| pf_clr_th | input | $clog2(DEPTH)+1 | Full-clear threshold when taken from ports |
| pe_set_th | input | $clog2(DEPTH)+1 | Empty-set threshold when taken from ports |
| pe_clr_th | input | $clog2(DEPTH)+1 | Empty-clear threshold when taken from ports |

## Verification
The bench fills the queue to the brim and then writes once more. A design that let the extra word in would return it during the drain, or would report one word too many. Both watermark flags are sampled inside their hysteresis bands on the way up and on the way down. A flag that followed a single threshold would flip there. In look-ahead mode, the bench checks that the first word shows up before any read and that back-to-back reads step through the words in order. An off-by-one in the prefetch would repeat or skip a word. A mid-stream reset and a lowered threshold port are also tried, to catch a state that survives reset and a threshold latched only at start-up.

// File: rtl/qbuf_pkg.sv
package qbuf_pkg;
  // Read-side timing variants
  typedef enum logic {
    QB_STD  = 1'b0,
    QB_FWFT = 1'b1
  } qbuf_mode_e;
endpackage

// File: rtl/qbuf_store.sv
module qbuf_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [DATA_W-1:0]          wdata,
  input  logic                       re,
  output logic [DATA_W-1:0]          rdata,
  output logic [$clog2(DEPTH):0]     cnt
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr;
  logic [AW-1:0]     rptr;

  // Array without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[wptr] <= wdata;
  end

  // Registered read port, doubles as the output data register
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (we) wptr <= wptr + 1'b1;
      if (re) rptr <= rptr + 1'b1;
      case ({we, re})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_NO_UNDERRUN: assert property (@(posedge clk) disable iff (rst)
    re |-> (cnt != '0)); // R8
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    we |-> (cnt != CW'(DEPTH))); // R7
endmodule

// File: rtl/qbuf_rdport.sv
module qbuf_rdport
  import qbuf_pkg::*;
#(
  parameter qbuf_mode_e MODE = QB_STD
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_en,
  input  logic mem_nz,
  output logic ram_re,
  output logic rd_acc,
  output logic shown_nxt,
  output logic rd_valid
);
  generate
    if (MODE == QB_FWFT) begin : g_fwft
      logic out_vld;
      assign rd_acc    = rd_en && out_vld;
      assign ram_re    = mem_nz && (!out_vld || rd_acc);
      assign shown_nxt = ram_re ? 1'b1 : (rd_acc ? 1'b0 : out_vld);
      always_ff @(posedge clk) begin
        if (rst) out_vld <= 1'b0;
        else     out_vld <= shown_nxt;
      end
      assign rd_valid = out_vld;

      AST_FT_SHOW: assert property (@(posedge clk) disable iff (rst)
        (!out_vld && mem_nz) |=> out_vld); // R3
    end else begin : g_std
      logic vld_q;
      assign rd_acc    = rd_en && mem_nz;
      assign ram_re    = rd_acc;
      assign shown_nxt = 1'b0;
      always_ff @(posedge clk) begin
        if (rst) vld_q <= 1'b0;
        else     vld_q <= rd_acc;
      end
      assign rd_valid = vld_q;
    end
  endgenerate
endmodule

// File: rtl/qbuf_flags.sv
module qbuf_flags
  import qbuf_pkg::*;
#(
  parameter int         DEPTH         = 16,
  parameter qbuf_mode_e MODE          = QB_STD,
  parameter bit         THR_FROM_PORT = 1'b0,
  parameter int         PF_SET        = 12,
  parameter int         PF_CLR        = 10,
  parameter int         PE_SET        = 3,
  parameter int         PE_CLR        = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic                   rd_acc,
  input  logic                   shown_nxt,
  input  logic [$clog2(DEPTH):0] pf_set_th,
  input  logic [$clog2(DEPTH):0] pf_clr_th,
  input  logic [$clog2(DEPTH):0] pe_set_th,
  input  logic [$clog2(DEPTH):0] pe_clr_th,
  output logic                   wr_acc,
  output logic [$clog2(DEPTH):0] occ,
  output logic                   full,
  output logic                   almost_full,
  output logic                   empty,
  output logic                   almost_empty,
  output logic                   prog_full,
  output logic                   prog_empty,
  output logic                   wr_ack,
  output logic                   overflow,
  output logic                   underflow
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [CW-1:0] occ_n;
  logic [CW-1:0] pfs, pfc, pes, pec;
  logic          empty_n;

  assign pfs = THR_FROM_PORT ? pf_set_th : CW'(PF_SET);
  assign pfc = THR_FROM_PORT ? pf_clr_th : CW'(PF_CLR);
  assign pes = THR_FROM_PORT ? pe_set_th : CW'(PE_SET);
  assign pec = THR_FROM_PORT ? pe_clr_th : CW'(PE_CLR);

  assign wr_acc  = wr_en && !full;
  assign occ_n   = occ + CW'(wr_acc) - CW'(rd_acc);
  assign empty_n = (MODE == QB_FWFT) ? !shown_nxt : (occ_n == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      occ          <= '0;
      full         <= 1'b0;
      almost_full  <= 1'b0;
      empty        <= 1'b1;
      almost_empty <= 1'b0;
      prog_full    <= 1'b0;
      prog_empty   <= 1'b1;
      wr_ack       <= 1'b0;
      overflow     <= 1'b0;
      underflow    <= 1'b0;
    end else begin
      occ          <= occ_n;
      full         <= (occ_n == CW'(DEPTH));
      almost_full  <= (occ_n == CW'(DEPTH - 1));
      empty        <= empty_n;
      almost_empty <= (occ_n == CW'(1));
      if (occ_n >= pfs)     prog_full <= 1'b1;
      else if (occ_n < pfc) prog_full <= 1'b0;
      if (occ_n <= pes)      prog_empty <= 1'b1;
      else if (occ_n > pec)  prog_empty <= 1'b0;
      wr_ack       <= wr_acc;
      overflow     <= wr_en && full;
      underflow    <= rd_en && !rd_acc;
    end
  end

  AST_OVF_DROP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_acc) |=> (occ == $past(occ))); // R7
  AST_FULL_STEP: assert property (@(posedge clk) disable iff (rst)
    $rose(full) |-> $past(almost_full)); // R5
  AST_ACK_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(wr_ack && overflow)); // R9
  AST_PF_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(prog_full) |-> (occ >= $past(pfs))); // R10
  AST_PE_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(prog_empty) |-> (occ <= $past(pes))); // R11
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(DEPTH)); // R13
endmodule

// File: rtl/qbuf_fifo.sv
module qbuf_fifo
  import qbuf_pkg::*;
#(
  parameter int         DATA_W        = 8,
  parameter int         DEPTH         = 16,
  parameter qbuf_mode_e MODE          = QB_STD,
  parameter bit         THR_FROM_PORT = 1'b0,
  parameter int         PF_SET        = 12,
  parameter int         PF_CLR        = 10,
  parameter int         PE_SET        = 3,
  parameter int         PE_CLR        = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [DATA_W-1:0]      wr_data,
  output logic                   full,
  output logic                   almost_full,
  output logic                   wr_ack,
  output logic                   overflow,
  output logic [$clog2(DEPTH):0] wr_count,
  input  logic                   rd_en,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   empty,
  output logic                   almost_empty,
  output logic                   rd_valid,
  output logic                   underflow,
  output logic [$clog2(DEPTH):0] rd_count,
  output logic                   prog_full,
  output logic                   prog_empty,
  input  logic [$clog2(DEPTH):0] pf_set_th,
  input  logic [$clog2(DEPTH):0] pf_clr_th,
  input  logic [$clog2(DEPTH):0] pe_set_th,
  input  logic [$clog2(DEPTH):0] pe_clr_th
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic          wr_acc, rd_acc, ram_re, shown_nxt;
  logic [CW-1:0] mem_cnt;
  logic [CW-1:0] occ;

  qbuf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_acc),
    .wdata (wr_data),
    .re    (ram_re),
    .rdata (rd_data),
    .cnt   (mem_cnt)
  );

  qbuf_rdport #(.MODE(MODE)) u_rdport (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .mem_nz    (mem_cnt != '0),
    .ram_re    (ram_re),
    .rd_acc    (rd_acc),
    .shown_nxt (shown_nxt),
    .rd_valid  (rd_valid)
  );

  qbuf_flags #(
    .DEPTH(DEPTH), .MODE(MODE), .THR_FROM_PORT(THR_FROM_PORT),
    .PF_SET(PF_SET), .PF_CLR(PF_CLR), .PE_SET(PE_SET), .PE_CLR(PE_CLR)
  ) u_flags (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .rd_acc       (rd_acc),
    .shown_nxt    (shown_nxt),
    .pf_set_th    (pf_set_th),
    .pf_clr_th    (pf_clr_th),
    .pe_set_th    (pe_set_th),
    .pe_clr_th    (pe_clr_th),
    .wr_acc       (wr_acc),
    .occ          (occ),
    .full         (full),
    .almost_full  (almost_full),
    .empty        (empty),
    .almost_empty (almost_empty),
    .prog_full    (prog_full),
    .prog_empty   (prog_empty),
    .wr_ack       (wr_ack),
    .overflow     (overflow),
    .underflow    (underflow)
  );

  assign wr_count = occ;
  assign rd_count = occ;
endmodule

// File: tb/qbuf_fifo_test.sv
`timescale 1ns/1ps
module qbuf_fifo_test;
  import qbuf_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  int n_run  = 0;
  int n_fail = 0;

  // standard-timing instance, thresholds from parameters (12/10, 3/5)
  logic       s_we = 0, s_re = 0;
  logic [7:0] s_wd = 0, s_rd;
  logic       s_full, s_af, s_ack, s_ovf, s_empty, s_ae, s_rv, s_unf, s_pf, s_pe;
  logic [4:0] s_wc, s_rc;

  qbuf_fifo #(.DATA_W(8), .DEPTH(16), .MODE(QB_STD), .THR_FROM_PORT(1'b0),
              .PF_SET(12), .PF_CLR(10), .PE_SET(3), .PE_CLR(5)) uut (
    .clk(clk), .rst(rst), .wr_en(s_we), .wr_data(s_wd), .full(s_full),
    .almost_full(s_af), .wr_ack(s_ack), .overflow(s_ovf), .wr_count(s_wc),
    .rd_en(s_re), .rd_data(s_rd), .empty(s_empty), .almost_empty(s_ae),
    .rd_valid(s_rv), .underflow(s_unf), .rd_count(s_rc), .prog_full(s_pf),
    .prog_empty(s_pe), .pf_set_th(5'd0), .pf_clr_th(5'd0),
    .pe_set_th(5'd0), .pe_clr_th(5'd0));

  // look-ahead instance, thresholds from ports
  logic       f_we = 0, f_re = 0;
  logic [7:0] f_wd = 0, f_rd;
  logic       f_full, f_af, f_ack, f_ovf, f_empty, f_ae, f_rv, f_unf, f_pf, f_pe;
  logic [3:0] f_wc, f_rc;
  logic [3:0] f_pfs = 4'd6, f_pfc = 4'd4, f_pes = 4'd1, f_pec = 4'd2;

  qbuf_fifo #(.DATA_W(8), .DEPTH(8), .MODE(QB_FWFT), .THR_FROM_PORT(1'b1)) uut_ft (
    .clk(clk), .rst(rst), .wr_en(f_we), .wr_data(f_wd), .full(f_full),
    .almost_full(f_af), .wr_ack(f_ack), .overflow(f_ovf), .wr_count(f_wc),
    .rd_en(f_re), .rd_data(f_rd), .empty(f_empty), .almost_empty(f_ae),
    .rd_valid(f_rv), .underflow(f_unf), .rd_count(f_rc), .prog_full(f_pf),
    .prog_empty(f_pe), .pf_set_th(f_pfs), .pf_clr_th(f_pfc),
    .pe_set_th(f_pes), .pe_clr_th(f_pec));

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk("R1 s_empty", int'(s_empty), 1);  chk("R1 s_pe", int'(s_pe), 1);
    chk("R1 s_full", int'(s_full), 0);    chk("R1 s_wc", int'(s_wc), 0);
    chk("R1 s_rc", int'(s_rc), 0);        chk("R1 s_rd", int'(s_rd), 0);
    chk("R1 s_pf", int'(s_pf), 0);        chk("R1 s_ack", int'(s_ack), 0);
    chk("R1 f_empty", int'(f_empty), 1);  chk("R1 f_rv", int'(f_rv), 0);
  endtask

  task automatic t_std_single();
    s_we = 1; s_wd = 8'hA5; tick(); s_we = 0;
    chk("R9 wr_ack", int'(s_ack), 1);
    chk("R13 count", int'(s_wc), 1);
    chk("R6 almost_empty", int'(s_ae), 1);
    chk("R6 empty", int'(s_empty), 0);
    chk("R2 no show", int'(s_rd), 0);
    tick();
    chk("R9 ack one cycle", int'(s_ack), 0);
    s_re = 1; tick(); s_re = 0;
    chk("R2 rd_valid", int'(s_rv), 1);
    chk("R2 rd_data", int'(s_rd), 8'hA5);
    chk("R6 empty", int'(s_empty), 1);
    tick();
    chk("R2 rd_valid drops", int'(s_rv), 0);
  endtask

  task automatic t_std_underflow();
    s_re = 1; tick(); s_re = 0;
    chk("R8 underflow", int'(s_unf), 1);
    chk("R8 no rd_valid", int'(s_rv), 0);
    chk("R8 count", int'(s_rc), 0);
    tick();
    chk("R8 pulse", int'(s_unf), 0);
  endtask

  task automatic t_std_fill_drain();
    for (int i = 0; i < 16; i++) begin
      s_we = 1; s_wd = 8'(i * 3 + 1); tick();
      if (i + 1 == 4)  chk("R11 pe hold rising", int'(s_pe), 1);
      if (i + 1 == 6)  chk("R11 pe clear", int'(s_pe), 0);
      if (i + 1 == 11) chk("R10 pf below", int'(s_pf), 0);
      if (i + 1 == 12) chk("R10 pf set", int'(s_pf), 1);
      if (i + 1 == 15) begin
        chk("R5 almost_full", int'(s_af), 1); chk("R5 not full", int'(s_full), 0);
      end
    end
    chk("R5 full", int'(s_full), 1);
    chk("R5 af off", int'(s_af), 0);
    s_wd = 8'hEE; tick(); s_we = 0;
    chk("R7 overflow", int'(s_ovf), 1);
    chk("R7 no ack", int'(s_ack), 0);
    chk("R7 count", int'(s_wc), 16);
    tick();
    chk("R7 pulse", int'(s_ovf), 0);
    for (int i = 0; i < 16; i++) begin
      s_re = 1; tick();
      chk("R4 order", int'(s_rd), i * 3 + 1);
      if (15 - i == 10) chk("R10 pf hold falling", int'(s_pf), 1);
      if (15 - i == 9)  chk("R10 pf clear", int'(s_pf), 0);
      if (15 - i == 4)  chk("R11 pe hold falling", int'(s_pe), 0);
      if (15 - i == 3)  chk("R11 pe set", int'(s_pe), 1);
    end
    s_re = 0;
    chk("R7 dropped word absent", int'(s_empty), 1);
  endtask

  task automatic t_std_simul();
    s_we = 1; s_wd = 8'h11; tick();
    s_wd = 8'h22; tick();
    s_wd = 8'h33; s_re = 1; tick();
    s_we = 0;
    chk("R13 simultaneous", int'(s_wc), 2);
    chk("R4 first", int'(s_rd), 8'h11);
    tick(); chk("R4 second", int'(s_rd), 8'h22);
    tick(); chk("R4 third", int'(s_rd), 8'h33);
    s_re = 0;
    chk("R13 drained", int'(s_rc), 0);
  endtask

  task automatic t_reset_mid();
    s_we = 1; s_wd = 8'h5A; tick(); s_we = 0;
    f_we = 1; f_wd = 8'h6B; tick(); f_we = 0; tick();
    rst = 1; tick(); rst = 0;
    chk("R1 s count", int'(s_wc), 0); chk("R1 s empty", int'(s_empty), 1);
    chk("R1 s rd_data", int'(s_rd), 0);
    chk("R1 f empty", int'(f_empty), 1); chk("R1 f rd_data", int'(f_rd), 0);
    chk("R1 f count", int'(f_wc), 0);
  endtask

  task automatic t_ft_show();
    f_we = 1; f_wd = 8'h3C; tick(); f_we = 0;
    chk("R3 not yet", int'(f_empty), 1);
    chk("R13 ft count", int'(f_wc), 1);
    tick();
    chk("R3 empty low", int'(f_empty), 0);
    chk("R3 rd_valid", int'(f_rv), 1);
    chk("R3 shown", int'(f_rd), 8'h3C);
    f_re = 1; tick(); f_re = 0;
    chk("R3 consumed", int'(f_empty), 1);
    chk("R3 count", int'(f_rc), 0);
    f_re = 1; tick(); f_re = 0;
    chk("R8 ft underflow", int'(f_unf), 1);
  endtask

  task automatic t_ft_advance();
    f_we = 1; f_wd = 8'h71; tick();
    f_wd = 8'h72; tick(); f_we = 0; tick();
    chk("R3 head", int'(f_rd), 8'h71);
    f_re = 1; tick();
    chk("R3 advance", int'(f_rd), 8'h72);
    chk("R3 still shown", int'(f_empty), 0);
    tick(); f_re = 0;
    chk("R3 last gone", int'(f_empty), 1);
  endtask

  task automatic t_ft_fill_drain();
    for (int i = 0; i < 8; i++) begin
      f_we = 1; f_wd = 8'(8'h80 + i); tick();
      if (i + 1 == 2) chk("R11 ft pe hold", int'(f_pe), 1);
      if (i + 1 == 3) chk("R11 ft pe clear", int'(f_pe), 0);
      if (i + 1 == 5) chk("R12 pf below port thr", int'(f_pf), 0);
      if (i + 1 == 6) chk("R12 pf at port thr", int'(f_pf), 1);
      if (i + 1 == 7) chk("R5 ft almost_full", int'(f_af), 1);
    end
    chk("R5 ft full", int'(f_full), 1);
    f_wd = 8'hEE; tick(); f_we = 0;
    chk("R7 ft overflow", int'(f_ovf), 1);
    chk("R4 ft head", int'(f_rd), 8'h80);
    for (int i = 1; i < 8; i++) begin
      f_re = 1; tick();
      chk("R4 ft order", int'(f_rd), 8'h80 + i);
      if (8 - i == 4) chk("R10 ft pf hold", int'(f_pf), 1);
      if (8 - i == 3) chk("R10 ft pf clear", int'(f_pf), 0);
    end
    tick(); f_re = 0;
    chk("R7 ft extra absent", int'(f_empty), 1);
  endtask

  task automatic t_ft_port_thr();
    f_pfs = 4'd2; f_pfc = 4'd1;
    f_we = 1; f_wd = 8'h01; tick();
    chk("R12 pf under lowered", int'(f_pf), 0);
    f_wd = 8'h02; tick(); f_we = 0;
    chk("R12 pf lowered thr", int'(f_pf), 1);
    f_re = 1; tick(); tick(); tick(); f_re = 0;
    chk("R12 pf clears", int'(f_pf), 0);
    f_pfs = 4'd6; f_pfc = 4'd4;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); tick(); tick();
    rst = 0;
    t_reset_state();
    t_std_single();
    t_std_underflow();
    t_std_fill_drain();
    t_std_simul();
    t_ft_show();
    t_ft_advance();
    t_ft_fill_drain();
    t_ft_port_thr();
    t_reset_mid();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule